// File: doc/BRIEF.md
# Cross-Trigger Routing Matrix

The block routes trigger input lines to trigger output lines through a small set of shared event channels. Each trigger input has a channel mask that lets it drive some channels. Each trigger output has a channel mask that chooses the channels it listens to. Software can also drive channels directly by setting, clearing or pulsing them. A trigger output latches on a rising edge of any channel in its mask and holds until software acknowledges it. One output, chosen by a parameter, also drives an interrupt line.

All configuration goes over a simple 32-bit register bus. Reads are combinational and return data while the read enable is high. Every write except a write to the lock register is dropped while the unit is locked. The unit leaves reset locked and disabled, so software must write the unlock key before it can configure anything.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset the unit is locked (lock status at 0xFB4 reads 1), the control register at 0x000 reads 0, every channel mask reads 0, all trigger outputs are 0 and the interrupt is low.
- R2: Writing 0xC5ACCE55 to 0xFB0 unlocks the unit, and the lock status then reads 0. Writing any other value to 0xFB0 locks it again, and the lock status then reads 1.
- R3: While the unit is locked, a write to any register other than 0xFB0 has no effect.
- R4: The channel mask of trigger input n is at 0x020+4n and the mask of trigger output m is at 0x0A0+4m. Bit c is channel c. Only the low 4 bits are stored, and bits above them read as 0.
- R5: When the unit is enabled and trigger input n rises, every channel c with bit c set in the mask of input n becomes active. Every trigger output whose mask holds such a channel reads 1 after the next clock edge, and no other output changes.
- R6: A latched trigger output stays at 1 after its cause goes away, until it is acknowledged.
- R7: While bit 0 of the control register is 0, channel outputs (status at 0x13C) read 0 and no trigger output is set, whether the activity comes from trigger inputs or from application writes.
- R8: Writing a bitmask to 0x010 clears exactly the trigger outputs whose bits are set. If an acknowledge and a new trigger edge reach the same output on the same clock edge, the acknowledge wins.
- R9: Writing a channel bitmask to 0x014 holds those channels active, and the mask reads back at 0x014. Writing a bitmask to 0x018 releases those channels.
- R10: Writing a bitmask to 0x01C makes those channels active for exactly one clock cycle, which is enough to latch the trigger outputs that listen to them.
- R11: The interrupt output equals the latched state of trigger output IRQ_SEL (default 2).
- R12: Outputs latch on channel rising edges only. A channel that stays high does not set an output again after that output has been acknowledged.
- R13: Address 0x130 reads the raw trigger inputs and 0x138 reads the channel inputs before the enable gate, whatever the enable state. 0x134 reads the latched trigger outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| trig_in | input | 8 | Trigger input lines |
| trig_out | output | 8 | Latched trigger output lines |
| irq | output | 1 | Interrupt from the selected trigger output |

## Verification
The bench sweeps every pairing of trigger input and trigger output through a rotating channel. A design with a swapped mask index or a wrong channel decode would light the wrong output or more than one output. It makes an acknowledge and a new trigger edge land on the same clock edge. A design that gives the trigger priority would leave that output set. It holds a channel high across an acknowledge, which catches a level-sensitive latch that fires again. It also drives a single-cycle application pulse, writes while the unit is disabled and writes while it is locked. These catch a pulse that lasts too long, routing that ignores the enable, and a lock that fails to drop writes.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int XT_AW = 12;
  typedef logic [XT_AW-1:0] xt_addr_t;

  localparam logic [31:0] XT_KEY = 32'hC5AC_CE55;

  localparam xt_addr_t A_CTRL     = 12'h000;
  localparam xt_addr_t A_ACK      = 12'h010;
  localparam xt_addr_t A_APP_SET  = 12'h014;
  localparam xt_addr_t A_APP_CLR  = 12'h018;
  localparam xt_addr_t A_APP_PLS  = 12'h01C;
  localparam xt_addr_t A_IN_BASE  = 12'h020;
  localparam xt_addr_t A_OUT_BASE = 12'h0A0;
  localparam xt_addr_t A_ST_TIN   = 12'h130;
  localparam xt_addr_t A_ST_TOUT  = 12'h134;
  localparam xt_addr_t A_ST_CIN   = 12'h138;
  localparam xt_addr_t A_ST_COUT  = 12'h13C;
  localparam xt_addr_t A_LOCK     = 12'hFB0;
  localparam xt_addr_t A_LOCK_ST  = 12'hFB4;

  // word address of slot idx in a per-line register array
  function automatic xt_addr_t xt_slot(input xt_addr_t base, input int idx);
    return base + xt_addr_t'(idx * 4);
  endfunction

  // true when a lock-register write carries the unlock key
  function automatic logic xt_is_key(input logic [31:0] d);
    return d == XT_KEY;
  endfunction
endpackage

// File: rtl/xtrig_regfile.sv
module xtrig_regfile
  import xtrig_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_OUT  = 8,
  parameter int N_CHAN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [XT_AW-1:0]         bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [31:0]              bus_rdata,
  input  logic [N_IN-1:0]          st_tin_i,
  input  logic [N_OUT-1:0]         st_tout_i,
  input  logic [N_CHAN-1:0]        st_cin_i,
  input  logic [N_CHAN-1:0]        st_cout_i,
  output logic                     en_o,
  output logic [N_IN*N_CHAN-1:0]   in_mask_o,
  output logic [N_OUT*N_CHAN-1:0]  out_mask_o,
  output logic [N_CHAN-1:0]        app_level_o,
  output logic [N_CHAN-1:0]        app_pulse_o,
  output logic [N_OUT-1:0]         ack_o
);
  logic                locked_q;
  logic                en_q;
  logic [N_CHAN-1:0]   in_mask_q  [N_IN];
  logic [N_CHAN-1:0]   out_mask_q [N_OUT];
  logic [N_CHAN-1:0]   app_level_q;
  logic [N_CHAN-1:0]   app_pulse_q;

  // named internal events
  logic lock_wr;
  logic wr_ok;
  logic pulse_wr;

  assign lock_wr  = bus_we && (bus_addr == A_LOCK);
  assign wr_ok    = bus_we && !locked_q && (bus_addr != A_LOCK);
  assign pulse_wr = wr_ok && (bus_addr == A_APP_PLS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (lock_wr) begin
      locked_q <= !xt_is_key(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      app_level_q <= '0;
      app_pulse_q <= '0;
      for (int n = 0; n < N_IN; n++)  in_mask_q[n]  <= '0;
      for (int m = 0; m < N_OUT; m++) out_mask_q[m] <= '0;
    end else begin
      app_pulse_q <= pulse_wr ? bus_wdata[N_CHAN-1:0] : '0;
      if (wr_ok) begin
        if (bus_addr == A_CTRL)    en_q <= bus_wdata[0];
        if (bus_addr == A_APP_SET) app_level_q <= app_level_q | bus_wdata[N_CHAN-1:0];
        if (bus_addr == A_APP_CLR) app_level_q <= app_level_q & ~bus_wdata[N_CHAN-1:0];
        for (int n = 0; n < N_IN; n++)
          if (bus_addr == xt_slot(A_IN_BASE, n)) in_mask_q[n] <= bus_wdata[N_CHAN-1:0];
        for (int m = 0; m < N_OUT; m++)
          if (bus_addr == xt_slot(A_OUT_BASE, m)) out_mask_q[m] <= bus_wdata[N_CHAN-1:0];
      end
    end
  end

  assign ack_o       = (wr_ok && bus_addr == A_ACK) ? bus_wdata[N_OUT-1:0] : '0;
  assign en_o        = en_q;
  assign app_level_o = app_level_q;
  assign app_pulse_o = app_pulse_q;

  for (genvar gn = 0; gn < N_IN; gn++) begin : g_in_flat
    assign in_mask_o[gn*N_CHAN +: N_CHAN] = in_mask_q[gn];
  end
  for (genvar gm = 0; gm < N_OUT; gm++) begin : g_out_flat
    assign out_mask_o[gm*N_CHAN +: N_CHAN] = out_mask_q[gm];
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CTRL:    rd_mux[0] = en_q;
      A_APP_SET: rd_mux[N_CHAN-1:0] = app_level_q;
      A_ST_TIN:  rd_mux[N_IN-1:0] = st_tin_i;
      A_ST_TOUT: rd_mux[N_OUT-1:0] = st_tout_i;
      A_ST_CIN:  rd_mux[N_CHAN-1:0] = st_cin_i;
      A_ST_COUT: rd_mux[N_CHAN-1:0] = st_cout_i;
      A_LOCK_ST: rd_mux[0] = locked_q;
      default:   rd_mux = '0;
    endcase
    for (int n = 0; n < N_IN; n++)
      if (bus_addr == xt_slot(A_IN_BASE, n)) rd_mux[N_CHAN-1:0] = in_mask_q[n];
    for (int m = 0; m < N_OUT; m++)
      if (bus_addr == xt_slot(A_OUT_BASE, m)) rd_mux[N_CHAN-1:0] = out_mask_q[m];
  end

  assign bus_rdata = bus_re ? rd_mux : '0;

  // R3: a locked unit keeps its enable through any non-lock write
  a_r3_locked_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_we && bus_addr != A_LOCK) |=> $stable(en_q));
  // R2: the key always opens the lock
  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && xt_is_key(bus_wdata)) |=> !locked_q);
  // R10: an application pulse is gone one cycle later unless written again
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    ((|app_pulse_q) && !pulse_wr) |=> (app_pulse_q == '0));
endmodule

// File: rtl/xtrig_chan_mux.sv
module xtrig_chan_mux #(
  parameter int N_IN   = 8,
  parameter int N_CHAN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [N_IN-1:0]         trig_i,
  input  logic [N_IN*N_CHAN-1:0]  in_mask_i,
  input  logic [N_CHAN-1:0]       app_level_i,
  input  logic [N_CHAN-1:0]       app_pulse_i,
  output logic [N_CHAN-1:0]       chan_in_o,
  output logic [N_CHAN-1:0]       chan_out_o,
  output logic [N_CHAN-1:0]       chan_rise_o
);
  // OR of every trigger input, each masked by its own channel mask
  function automatic logic [N_CHAN-1:0] route_in(
    input logic [N_IN-1:0] t, input logic [N_IN*N_CHAN-1:0] msk);
    logic [N_CHAN-1:0] acc;
    acc = '0;
    for (int n = 0; n < N_IN; n++)
      if (t[n]) acc = acc | msk[n*N_CHAN +: N_CHAN];
    return acc;
  endfunction

  logic [N_CHAN-1:0] chan_prev_q;

  assign chan_in_o  = route_in(trig_i, in_mask_i) | app_level_i | app_pulse_i;
  assign chan_out_o = en_i ? chan_in_o : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_prev_q <= '0;
    else        chan_prev_q <= chan_out_o;
  end

  assign chan_rise_o = chan_out_o & ~chan_prev_q;

  // R12: a channel that was high on the previous cycle cannot report a rise
  a_r12_no_rise_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(chan_out_o) & chan_rise_o)) == 1'b0);
endmodule

// File: rtl/xtrig_out_latch.sv
module xtrig_out_latch #(
  parameter int N_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CHAN-1:0] rise_i,
  input  logic [N_CHAN-1:0] mask_i,
  input  logic              ack_i,
  output logic              q_o
);
  logic hit;
  logic q;

  assign hit = |(rise_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (ack_i) q <= 1'b0;
    else if (hit)   q <= 1'b1;
  end

  assign q_o = q;

  // R8: acknowledge beats a trigger edge on the same clock
  a_r8_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !q_o);
  // R6: a set output holds until acknowledged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !ack_i) |=> q_o);
  // R5: an output only sets because a listened channel rose
  a_r5_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(hit));
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix
  import xtrig_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter int N_CHAN  = 4,
  parameter int IRQ_SEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [N_IN-1:0]   trig_in,
  output logic [N_OUT-1:0]  trig_out,
  output logic              irq
);
  logic                     ctrl_en;
  logic [N_IN*N_CHAN-1:0]   in_mask;
  logic [N_OUT*N_CHAN-1:0]  out_mask;
  logic [N_CHAN-1:0]        app_level;
  logic [N_CHAN-1:0]        app_pulse;
  logic [N_OUT-1:0]         ack_vec;
  logic [N_CHAN-1:0]        chan_in;
  logic [N_CHAN-1:0]        chan_out;
  logic [N_CHAN-1:0]        chan_rise;
  logic [N_OUT-1:0]         tout_q;

  xtrig_regfile #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CHAN(N_CHAN)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .st_tin_i    (trig_in),
    .st_tout_i   (tout_q),
    .st_cin_i    (chan_in),
    .st_cout_i   (chan_out),
    .en_o        (ctrl_en),
    .in_mask_o   (in_mask),
    .out_mask_o  (out_mask),
    .app_level_o (app_level),
    .app_pulse_o (app_pulse),
    .ack_o       (ack_vec)
  );

  xtrig_chan_mux #(.N_IN(N_IN), .N_CHAN(N_CHAN)) u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ctrl_en),
    .trig_i      (trig_in),
    .in_mask_i   (in_mask),
    .app_level_i (app_level),
    .app_pulse_i (app_pulse),
    .chan_in_o   (chan_in),
    .chan_out_o  (chan_out),
    .chan_rise_o (chan_rise)
  );

  for (genvar gm = 0; gm < N_OUT; gm++) begin : g_out
    xtrig_out_latch #(.N_CHAN(N_CHAN)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (chan_rise),
      .mask_i (out_mask[gm*N_CHAN +: N_CHAN]),
      .ack_i  (ack_vec[gm]),
      .q_o    (tout_q[gm])
    );
  end

  assign trig_out = tout_q;
  assign irq      = tout_q[IRQ_SEL];

  // R7: with the unit disabled and no acknowledge, outputs do not move
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && ack_vec == '0) |=> $stable(tout_q));
  // R11: the interrupt stays up until its own output is acknowledged
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_vec[IRQ_SEL]) |=> irq);
endmodule

// File: tb/xtrig_matrix_test.sv
module xtrig_matrix_test;
  localparam int NI = 8, NO = 8, NC = 4, ISEL = 2;
  localparam logic [11:0] R_CTRL = 12'h000, R_ACK = 12'h010, R_SET = 12'h014,
    R_CLR = 12'h018, R_PLS = 12'h01C, R_INM = 12'h020, R_OUTM = 12'h0A0,
    R_TIN = 12'h130, R_TOUT = 12'h134, R_CIN = 12'h138, R_COUT = 12'h13C,
    R_LCK = 12'hFB0, R_LST = 12'hFB4;
  localparam logic [31:0] KEY = 32'hC5ACCE55;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic we = 0, re = 0;
  logic [NI-1:0] tin = '0;
  logic [NO-1:0] tout;
  logic irq;
  int total = 0, bad = 0, cyc = 0;
  logic done = 0;

  always #5 clk = ~clk;

  xtrig_matrix #(.N_IN(NI), .N_OUT(NO), .N_CHAN(NC), .IRQ_SEL(ISEL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_re(re), .bus_rdata(rdata), .trig_in(tin), .trig_out(tout), .irq(irq));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, got cycle %0d expected finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; re = 1; #1; d = rdata; re = 0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    rd(R_LST, v);  chk("R1 lock status", v, 1);
    rd(R_CTRL, v); chk("R1 ctrl", v, 0);
    rd(R_INM + 12'd12, v); chk("R1 in mask", v, 0);
    rd(R_OUTM + 12'd28, v); chk("R1 out mask", v, 0);
    chk("R1 trig_out", {24'd0, tout}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3 writes dropped while locked
    wr(R_CTRL, 1); rd(R_CTRL, v); chk("R3 ctrl locked", v, 0);
    wr(R_INM, 32'hF); rd(R_INM, v); chk("R3 mask locked", v, 0);
    wr(R_LCK, KEY - 1); rd(R_LST, v); chk("R2 wrong key", v, 1);

    // R2 unlock
    wr(R_LCK, KEY); rd(R_LST, v); chk("R2 unlocked", v, 0);

    // R4 stored width
    wr(R_INM + 12'd20, 32'hFFFFFFFF); rd(R_INM + 12'd20, v); chk("R4 in mask width", v, 32'hF);
    wr(R_OUTM + 12'd28, 32'hA5A5A5A5); rd(R_OUTM + 12'd28, v); chk("R4 out mask width", v, 32'h5);
    wr(R_INM + 12'd20, 0); wr(R_OUTM + 12'd28, 0);

    // R7 and R13 while disabled
    wr(R_INM, 1); wr(R_OUTM, 1);
    tin = 8'h01; tick(); tick();
    chk("R7 no route disabled", {24'd0, tout}, 0);
    rd(R_COUT, v); chk("R7 chan out disabled", v, 0);
    rd(R_TIN, v);  chk("R13 raw trig in", v, 1);
    rd(R_CIN, v);  chk("R13 chan in ungated", v, 1);
    tin = 0;
    wr(R_INM, 0); wr(R_OUTM, 0);
    wr(R_CTRL, 1); rd(R_CTRL, v); chk("R2 ctrl after unlock", v, 1);

    // R5/R6 sweep over every input/output pairing
    for (int n = 0; n < NI; n++) begin
      for (int m = 0; m < NO; m++) begin
        int c;
        c = (n + m) % NC;
        wr(R_INM + 12'(4 * n), 32'(1 << c));
        wr(R_OUTM + 12'(4 * m), 32'(1 << c));
        tin = NI'(1 << n); tick();
        chk("R5 route", {24'd0, tout}, 32'(1 << m));
        rd(R_CIN, v);  chk("R13 chan in", v, 32'(1 << c));
        rd(R_TOUT, v); chk("R13 tout status", v, 32'(1 << m));
        tin = 0; tick(); tick();
        chk("R6 hold after drop", {24'd0, tout}, 32'(1 << m));
        chk("R11 irq follows", {31'd0, irq}, (m == ISEL) ? 32'd1 : 32'd0);
        wr(R_ACK, 32'hFF);
        chk("R8 ack clears", {24'd0, tout}, 0);
        wr(R_INM + 12'(4 * n), 0);
        wr(R_OUTM + 12'(4 * m), 0);
      end
    end

    // R8 selective acknowledge
    wr(R_INM, 32'hF);
    for (int m = 0; m < NO; m++) wr(R_OUTM + 12'(4 * m), 1);
    tin = 8'h01; tick(); tin = 0; tick();
    chk("R5 fan-out", {24'd0, tout}, 32'hFF);
    chk("R11 irq set", {31'd0, irq}, 1);
    wr(R_ACK, 32'h0F);
    chk("R8 partial ack", {24'd0, tout}, 32'hF0);
    chk("R11 irq cleared", {31'd0, irq}, 0);
    wr(R_ACK, 32'hF0);
    chk("R8 rest acked", {24'd0, tout}, 0);

    // R8 acknowledge beats a same-edge trigger
    @(negedge clk); tin = 8'h01; addr = R_ACK; wdata = 32'h01; we = 1;
    @(negedge clk); we = 0;
    chk("R8 ack priority", {24'd0, tout}, 32'hFE);
    tick();
    chk("R12 held channel no retrigger", {24'd0, tout}, 32'hFE);
    wr(R_ACK, 32'hFE); tick(); tick();
    chk("R12 still clear while held", {24'd0, tout}, 0);
    tin = 0; tick(); tin = 8'h01; tick();
    chk("R12 re-armed on new edge", {24'd0, tout}, 32'hFF);
    tin = 0; wr(R_ACK, 32'hFF);
    wr(R_INM, 0);

    // R9 application set/clear; output m listens to channel m%4
    for (int m = 0; m < NO; m++) wr(R_OUTM + 12'(4 * m), 32'(1 << (m % NC)));
    wr(R_SET, 32'h2);
    rd(R_COUT, v); chk("R9 set drives channel", v, 32'h2);
    rd(R_SET, v);  chk("R9 set readback", v, 32'h2);
    tick();
    chk("R9 set latches outputs", {24'd0, tout}, 32'h22);
    wr(R_CLR, 32'h2);
    rd(R_COUT, v); chk("R9 clear releases", v, 0);
    wr(R_ACK, 32'hFF);

    // R10 application pulse
    wr(R_PLS, 32'h8);
    rd(R_COUT, v); chk("R10 pulse active", v, 32'h8);
    tick();
    rd(R_COUT, v); chk("R10 pulse gone", v, 0);
    chk("R10 pulse latched", {24'd0, tout}, 32'h88);
    chk("R11 irq off", {31'd0, irq}, 0);
    wr(R_ACK, 32'hFF);
    wr(R_PLS, 32'h4); tick();
    chk("R11 irq from pulse", {31'd0, irq}, 1);
    wr(R_ACK, 32'h40);
    chk("R11 other ack keeps irq", {31'd0, irq}, 1);
    wr(R_ACK, 32'h04);
    chk("R11 own ack drops irq", {31'd0, irq}, 0);

    // R2 relock, R3 write ignored
    wr(R_LCK, 0); rd(R_LST, v); chk("R2 relocked", v, 1);
    wr(R_CTRL, 0); rd(R_CTRL, v); chk("R3 disable ignored", v, 1);
    wr(R_LCK, KEY);

    // R7 application pulse while disabled
    wr(R_CTRL, 0);
    wr(R_PLS, 32'h1); tick();
    chk("R7 pulse disabled", {24'd0, tout}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule